// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This unit is the multiply path of a 16-bit signal-processing datapath. Each request names an operation, one of six fixed pairings of source registers, an optional sign flip for the product, and the current 36-bit accumulator value. The accumulator is split into a 4-bit extension, a 16-bit high word and a 16-bit low word. The unit returns the new accumulator value one clock later. It also returns a three-bit write mask that tells the register file which of the three portions to update.

Four operations are offered:

- **Integer multiply** keeps the low 16 bits of the integer product in the high word and leaves the low word alone.
- **Fractional multiply** writes the doubled (Q15 × Q15 → Q31) product to the whole accumulator.
- **Fractional multiply-accumulate** adds the product to the accumulator.
- **Rounding multiply-accumulate** rounds the sum to nearest-even at the high-word boundary.

A request that names an unused pairing code is refused. The unit flags it and the accumulator passes through unchanged.

Top module: `frac_mac_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low in the cycle after an edge that sampled it low.
- R2: `pair_sel` picks the operands as follows:

  | Code | First operand | Second operand |
  |------|---------------|----------------|
  | 0 | `y1` | `x0` |
  | 1 | `y0` | `x0` |
  | 2 | `y1` | `y0` |
  | 3 | `y0` | `y0` |
  | 4 | `a1` | `y0` |
  | 5 | `b1` | `y1` |

  Codes 6 and 7 are refused: `sel_err`=1, `wr_mask`=000, `ovf`=0 and `acc_out` equals `acc_in`.
- R3: `op`=0 (integer multiply) behaves as follows:
  - `acc_out[31:16]` holds bits 15:0 of the signed integer product.
  - `acc_out[35:32]` repeats bit 15 of that product.
  - `acc_out[15:0]` equals `acc_in[15:0]`.
  - `wr_mask`=110.
  - `negate` has no effect.
- R4: `op`=1 (fractional multiply) writes the signed 32-bit product, sign-extended to 36 bits and shifted left by one, to `acc_out`. The value is two's-complement negated when `negate`=1. `wr_mask`=111. Mask bit 2 is the extension, bit 1 the high word and bit 0 the low word.
- R5: `op`=2 (multiply-accumulate) gives `acc_out` = `acc_in` + (the R4 product), wrapped to 36 bits, with `wr_mask`=111.
- R6: `op`=3 (rounding multiply-accumulate) forms the R5 sum and then rounds it at bit 15:
  - The sum is rounded up by 2^16 when bits 15:0 exceed 0x8000.
  - On a tie, where bits 15:0 equal 0x8000, it is rounded up only if bit 16 is 1.
  - Bits 15:0 of the result are then cleared.
  - `wr_mask`=111.
- R7: For `op`=2 and `op`=3, `ovf` is 1 when either of the following holds:
  - the exact sum falls outside the signed 36-bit range;
  - for `op`=3, rounding carries a non-negative sum to a negative result.

  For `op`=0 and `op`=1, `ovf` is 0.
- R8: A fractional product of 0x8000 by 0x8000 gives +1.0, that is `acc_out`=0x0_8000_0000, with no wrap.
- R9: While `rst_n` is low and after its release, `out_valid`, `acc_out`, `wr_mask`, `ovf` and `sel_err` are all zero until the first accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation: 0 integer, 1 fractional multiply, 2 accumulate, 3 rounding accumulate |
| pair_sel | input | 3 | Operand pairing code |
| negate | input | 1 | Negate the fractional product |
| x0 | input | 16 | Source register X0 |
| y0 | input | 16 | Source register Y0 |
| y1 | input | 16 | Source register Y1 |
| a1 | input | 16 | High word of accumulator A |
| b1 | input | 16 | High word of accumulator B |
| acc_in | input | 36 | Current destination accumulator |
| out_valid | output | 1 | Result strobe |
| acc_out | output | 36 | New accumulator value |
| wr_mask | output | 3 | Portions to write: extension, high, low |
| ovf | output | 1 | Accumulation overflow |
| sel_err | output | 1 | Refused pairing code |

## Verification
The bench builds the unit with its default widths: 16-bit operands and a 4-bit extension. At these widths, a 64-bit integer reference model can hold the exact, unwrapped sum. The 36-bit range limit is only about sixteen product magnitudes away from the largest product. Random accumulator values therefore cross the overflow boundary often enough, and directed values place the sum exactly on rounding ties and on the carry into the sign bit.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [1:0] {
    OP_IMUL  = 2'd0,
    OP_FMUL  = 2'd1,
    OP_FMAC  = 2'd2,
    OP_FMACR = 2'd3
  } fmac_op_e;

  localparam int PAIR_W = 3;
  localparam int MASK_W = 3;
endpackage

// File: rtl/fmac_pair_sel.sv
module fmac_pair_sel #(
  parameter int DW = 16
) (
  input  logic [2:0]    sel,
  input  logic [DW-1:0] x0,
  input  logic [DW-1:0] y0,
  input  logic [DW-1:0] y1,
  input  logic [DW-1:0] a1,
  input  logic [DW-1:0] b1,
  output logic [DW-1:0] opa,
  output logic [DW-1:0] opb,
  output logic          pair_ok
);
  always_comb begin
    opa     = '0;
    opb     = '0;
    pair_ok = 1'b1;
    unique case (sel)
      3'd0: begin opa = y1; opb = x0; end
      3'd1: begin opa = y0; opb = x0; end
      3'd2: begin opa = y1; opb = y0; end
      3'd3: begin opa = y0; opb = y0; end
      3'd4: begin opa = a1; opb = y0; end
      3'd5: begin opa = b1; opb = y1; end
      default: pair_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/fmac_product.sv
module fmac_product #(
  parameter int DW   = 16,
  parameter int EXTW = 4
) (
  input  logic [DW-1:0]          opa,
  input  logic [DW-1:0]          opb,
  input  logic                   negate,
  output logic [EXTW+2*DW-1:0]   frac_p,
  output logic [DW-1:0]          int_lo
);
  localparam int ACCW = EXTW + 2*DW;
  localparam int PW   = 2*DW;

  function automatic logic [PW-1:0] smul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [PW-1:0] p;
    p = $signed(a) * $signed(b);
    return p;
  endfunction

  function automatic logic [ACCW-1:0] to_frac(input logic [PW-1:0] p, input logic neg);
    logic [ACCW-1:0] ext;
    logic [ACCW-1:0] dbl;
    ext = {{EXTW{p[PW-1]}}, p};
    dbl = ext << 1;
    return neg ? (~dbl + {{(ACCW-1){1'b0}}, 1'b1}) : dbl;
  endfunction

  logic [PW-1:0] prod;

  assign prod   = smul(opa, opb);
  assign frac_p = to_frac(prod, negate);
  assign int_lo = prod[DW-1:0];
endmodule

// File: rtl/fmac_accum.sv
module fmac_accum
  import fmac_pkg::*;
#(
  parameter int DW   = 16,
  parameter int EXTW = 4
) (
  input  fmac_op_e               op,
  input  logic [EXTW+2*DW-1:0]   acc_in,
  input  logic [EXTW+2*DW-1:0]   frac_p,
  input  logic [DW-1:0]          int_lo,
  output logic [EXTW+2*DW-1:0]   res,
  output logic [MASK_W-1:0]      mask,
  output logic                   add_ovf,
  output logic                   rnd_ovf
);
  localparam int ACCW = EXTW + 2*DW;
  localparam int HIW  = ACCW - DW;

  function automatic logic [ACCW-1:0] conv_round(input logic [ACCW-1:0] v);
    logic          up;
    logic [HIW-1:0] hi;
    up = v[DW-1] && ((|v[DW-2:0]) || v[DW]);
    hi = v[ACCW-1:DW] + {{(HIW-1){1'b0}}, up};
    return {hi, {DW{1'b0}}};
  endfunction

  function automatic logic sum_ovf(input logic [ACCW-1:0] a, input logic [ACCW-1:0] b,
                                   input logic [ACCW-1:0] s);
    return (a[ACCW-1] == b[ACCW-1]) && (s[ACCW-1] != a[ACCW-1]);
  endfunction

  logic [ACCW-1:0] sum;
  logic [ACCW-1:0] rnd;

  assign sum = acc_in + frac_p;
  assign rnd = conv_round(sum);

  always_comb begin
    res     = acc_in;
    mask    = 3'b111;
    add_ovf = 1'b0;
    rnd_ovf = 1'b0;
    unique case (op)
      OP_IMUL: begin
        res  = {{EXTW{int_lo[DW-1]}}, int_lo, acc_in[DW-1:0]};
        mask = 3'b110;
      end
      OP_FMUL: res = frac_p;
      OP_FMAC: begin
        res     = sum;
        add_ovf = sum_ovf(acc_in, frac_p, sum);
      end
      OP_FMACR: begin
        res     = rnd;
        add_ovf = sum_ovf(acc_in, frac_p, sum);
        rnd_ovf = !sum[ACCW-1] && rnd[ACCW-1];
      end
      default: res = acc_in;
    endcase
  end
endmodule

// File: rtl/frac_mac_unit.sv
module frac_mac_unit
  import fmac_pkg::*;
#(
  parameter int DW   = 16,
  parameter int EXTW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           op,
  input  logic [2:0]           pair_sel,
  input  logic                 negate,
  input  logic [DW-1:0]        x0,
  input  logic [DW-1:0]        y0,
  input  logic [DW-1:0]        y1,
  input  logic [DW-1:0]        a1,
  input  logic [DW-1:0]        b1,
  input  logic [EXTW+2*DW-1:0] acc_in,
  output logic                 out_valid,
  output logic [EXTW+2*DW-1:0] acc_out,
  output logic [2:0]           wr_mask,
  output logic                 ovf,
  output logic                 sel_err
);
  localparam int ACCW = EXTW + 2*DW;

  fmac_op_e        op_e;
  logic [DW-1:0]   opa, opb, int_lo;
  logic            pair_ok, add_ovf, rnd_ovf;
  logic [ACCW-1:0] frac_p, res;
  logic [2:0]      mask;

  assign op_e = fmac_op_e'(op);

  fmac_pair_sel #(.DW(DW)) u_sel (
    .sel(pair_sel), .x0(x0), .y0(y0), .y1(y1), .a1(a1), .b1(b1),
    .opa(opa), .opb(opb), .pair_ok(pair_ok)
  );

  fmac_product #(.DW(DW), .EXTW(EXTW)) u_prod (
    .opa(opa), .opb(opb), .negate(negate && (op_e != OP_IMUL)),
    .frac_p(frac_p), .int_lo(int_lo)
  );

  fmac_accum #(.DW(DW), .EXTW(EXTW)) u_acc (
    .op(op_e), .acc_in(acc_in), .frac_p(frac_p), .int_lo(int_lo),
    .res(res), .mask(mask), .add_ovf(add_ovf), .rnd_ovf(rnd_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      wr_mask   <= '0;
      ovf       <= 1'b0;
      sel_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (pair_ok) begin
          acc_out <= res;
          wr_mask <= mask;
          ovf     <= add_ovf | rnd_ovf;
          sel_err <= 1'b0;
        end else begin
          acc_out <= acc_in;
          wr_mask <= 3'b000;
          ovf     <= 1'b0;
          sel_err <= 1'b1;
        end
      end
    end
  end

  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  a_r2_refused_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pair_ok) |=> (sel_err && wr_mask == 3'b000 && acc_out == $past(acc_in)));
  // R3
  a_r3_low_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_ok && op_e == OP_IMUL) |=>
      (acc_out[DW-1:0] == $past(acc_in[DW-1:0]) && wr_mask == 3'b110));
  // R4
  a_r4_frac_even: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_ok && op_e == OP_FMUL) |=> (!acc_out[0] && wr_mask == 3'b111));
  // R6
  a_r6_low_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_ok && op_e == OP_FMACR) |=> (acc_out[DW-1:0] == '0));
  // R7
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_e == OP_IMUL || op_e == OP_FMUL)) |=> !ovf);
endmodule

// File: tb/frac_mac_unit_bench.sv
`timescale 1ns/1ps
module frac_mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = '0;
  logic [2:0]  pair_sel = '0;
  logic        negate = 1'b0;
  logic [15:0] x0 = '0, y0 = '0, y1 = '0, a1 = '0, b1 = '0;
  logic [35:0] acc_in = '0;
  logic        out_valid, ovf, sel_err;
  logic [35:0] acc_out;
  logic [2:0]  wr_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  frac_mac_unit u_frac_mac_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .pair_sel(pair_sel),
    .negate(negate), .x0(x0), .y0(y0), .y1(y1), .a1(a1), .b1(b1), .acc_in(acc_in),
    .out_valid(out_valid), .acc_out(acc_out), .wr_mask(wr_mask), .ovf(ovf), .sel_err(sel_err)
  );

  localparam longint MAXV = (64'sd1 <<< 35) - 1;
  localparam longint MINV = -(64'sd1 <<< 35);

  function automatic longint s36(input logic [35:0] v);
    return v[35] ? longint'(v) - (64'sd1 <<< 36) : longint'(v);
  endfunction

  function automatic longint s16(input logic [15:0] v);
    return v[15] ? longint'(v) - 65536 : longint'(v);
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [2:0] s, input bit n,
                       input logic [35:0] acc);
    logic [15:0] a, b, lo;
    longint p, f, sm, r;
    logic [35:0] e_acc;
    logic [2:0]  e_mask;
    bit e_ovf, e_err;
    string tag;
    @(negedge clk);
    op = o; pair_sel = s; negate = n; acc_in = acc; in_valid = 1'b1;
    e_err = 1'b0; e_ovf = 1'b0; a = '0; b = '0;
    case (s)
      3'd0: begin a = y1; b = x0; end
      3'd1: begin a = y0; b = x0; end
      3'd2: begin a = y1; b = y0; end
      3'd3: begin a = y0; b = y0; end
      3'd4: begin a = a1; b = y0; end
      3'd5: begin a = b1; b = y1; end
      default: e_err = 1'b1;
    endcase
    p = s16(a) * s16(b);
    f = n ? -(2 * p) : 2 * p;
    sm = s36(acc) + f;
    if (e_err) begin
      tag = "R2"; e_acc = acc; e_mask = 3'b000;
    end else if (o == 2'd0) begin
      tag = "R3"; lo = p[15:0];
      e_acc = {{4{lo[15]}}, lo, acc[15:0]}; e_mask = 3'b110;
    end else if (o == 2'd1) begin
      tag = "R4"; e_acc = f[35:0]; e_mask = 3'b111;
    end else if (o == 2'd2) begin
      tag = "R5"; e_acc = sm[35:0]; e_mask = 3'b111;
      e_ovf = (sm > MAXV) || (sm < MINV);
    end else begin
      tag = "R6"; e_mask = 3'b111;
      r = sm;
      if ((sm & 64'hFFFF) > 64'h8000 || ((sm & 64'hFFFF) == 64'h8000 && sm[16])) r = sm + 65536;
      r = r & ~64'hFFFF;
      e_acc = r[35:0];
      e_ovf = (sm > MAXV) || (sm < MINV) || (s36(sm[35:0]) >= 0 && s36(r[35:0]) < 0);
    end
    @(negedge clk);
    chk("R1", "out_valid", longint'(out_valid), 1);
    chk(tag, "acc_out", longint'(acc_out), longint'(e_acc));
    chk(tag, "wr_mask", longint'(wr_mask), longint'(e_mask));
    chk("R7", "ovf", longint'(ovf), longint'(e_ovf));
    chk("R2", "sel_err", longint'(sel_err), longint'(e_err));
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7531));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9", "out_valid", longint'(out_valid), 0);
    chk("R9", "acc_out", longint'(acc_out), 0);
    chk("R9", "wr_mask", longint'(wr_mask), 0);
    chk("R9", "ovf", longint'(ovf), 0);
    chk("R9", "sel_err", longint'(sel_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "acc_out after release", longint'(acc_out), 0);

    // R8 -1 x -1 fractional
    a1 = 16'h8000; y0 = 16'h8000;
    apply(2'd1, 3'd4, 1'b0, 36'h0);
    chk("R8", "plus one", longint'(acc_out), 64'h0_8000_0000);
    // R3 negate ignored, low word kept
    y1 = 16'h0123; x0 = 16'hFF00;
    apply(2'd0, 3'd0, 1'b1, 36'hA_5555_BEEF);
    // R2 refused codes
    apply(2'd2, 3'd6, 1'b0, 36'h3_1234_5678);
    apply(2'd3, 3'd7, 1'b1, 36'hF_0000_0001);
    // R6 ties: zero product from y0*y0
    y0 = 16'h0000;
    apply(2'd3, 3'd3, 1'b0, 36'h0_0001_8000);
    chk("R6", "tie odd rounds up", longint'(acc_out), 64'h0_0002_0000);
    apply(2'd3, 3'd3, 1'b0, 36'h0_0002_8000);
    chk("R6", "tie even stays", longint'(acc_out), 64'h0_0002_0000);
    apply(2'd3, 3'd3, 1'b0, 36'h0_0002_8001);
    // R7 rounding carries into sign
    apply(2'd3, 3'd3, 1'b0, 36'h7_FFFF_C000);
    chk("R7", "round overflow", longint'(ovf), 1);
    // R7 accumulation overflow both ways
    y1 = 16'h7FFF; b1 = 16'h7FFF;
    apply(2'd2, 3'd5, 1'b0, 36'h7_FFFF_0000);
    apply(2'd2, 3'd5, 1'b1, 36'h8_0000_0000);
    // R1 idle
    @(negedge clk);
    chk("R1", "idle", longint'(out_valid), 0);

    for (int i = 0; i < 600; i++) begin
      logic [35:0] acc;
      x0 = 16'($urandom); y0 = 16'($urandom); y1 = 16'($urandom);
      a1 = 16'($urandom); b1 = 16'($urandom);
      if ($urandom_range(0, 9) == 0) begin x0 = 16'h8000; y0 = 16'h8000; y1 = 16'h8000; end
      acc = {4'($urandom), 32'($urandom)};
      if ($urandom_range(0, 3) == 0) acc[34:31] = acc[35] ? 4'h0 : 4'hF;
      apply(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 1'($urandom), acc);
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
        chk("R1", "gap idle", longint'(out_valid), 0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule